// File: doc/BRIEF.md
# Flash Program/Erase Suspend Sequencer

This block runs the short command sequences that pause and restart a long program or erase operation inside a serial flash. It sits next to the serial transaction engine. It takes three request pulses: suspend, automatic suspend, and resume. It hands the engine one command at a time over a request/acknowledge port. First it sends an 8-bit suspend or resume opcode. Then it can wait a programmed number of clock cycles. Then it reads the flash status register, one or two bytes, with a programmable poll command, and repeats the read until the flash reports the expected state.

Completion is judged from the write-in-progress flag and from a group of suspend indicator bits. The indicator bits are found by XOR-ing the returned status with a programmable 16-bit mask. If the indicator check keeps failing, a retry limit turns it into a pass. A finished suspend can chain straight into a resume. The block keeps a suspended flag and two interrupt sources, one for suspend-end and one for resume-end, each with raw, enable, clear and masked status bits.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: After reset `cmd_req_o` is 0, `suspended_o` is 0, `irq_raw_o` and `irq_st_o` are 2'b00, and `irq_o` is 0.
- R2: A pulse on `sus_req_i` or `auto_sus_req_i` starts a suspend sequence. Its first command has `cmd_code_o` = `sus_opcode_i` zero-extended, `cmd_wide_o` = 0 and `cmd_rd_bytes_o` = 0.
- R3: A pulse on `res_req_i` starts a resume sequence. Its first command carries `res_opcode_i` zero-extended, with `cmd_wide_o` = 0 and `cmd_rd_bytes_o` = 0.
- R4: Every status poll command carries `poll_cmd_i` in full with `cmd_wide_o` = 1 when `poll_cmd_wide_i` = 1. When `poll_cmd_wide_i` = 0 it carries only `poll_cmd_i[7:0]`, zero-extended, with `cmd_wide_o` = 0. `cmd_rd_bytes_o` is 2 when `poll_two_byte_i` = 1 and 1 otherwise.
- R5: When waiting is enabled for the current direction, the first poll request rises exactly `wait_base_i` x 4 cycles after the opcode acknowledge when the long select for that direction is 0, and `wait_base_i` x 128 cycles after it when the long select is 1. With waiting disabled it rises in the cycle right after the acknowledge.
- R6: The write-in-progress flag is status bit 0. While it reads 1, the block issues another poll one idle cycle after the previous acknowledge. With the direction's check enable at 0, a poll whose bit 0 reads 0 ends the sequence.
- R7: With the direction's check enable at 1, the indicator vector is status XOR `sus_mask_i`. When a single byte is read, bits 15:8 of both the status and the mask count as 0. A suspend completes when bit 0 is 0 and the vector is nonzero. A resume completes when bit 0 is 0 and the vector is zero.
- R8: A poll whose bit 0 is 0 but whose indicator check fails counts as a failure. The failure that brings the count up to `retry_limit_i` is treated as a pass. A limit of 0 behaves like 1.
- R9: `suspended_o` goes to 1 when a suspend sequence completes and to 0 when a resume sequence completes.
- R10: `irq_raw_o[0]` is set when a suspend completes and `irq_raw_o[1]` when a resume completes. A 1 on `irq_clr_i[n]` clears raw bit n. `irq_st_o` equals `irq_raw_o & irq_ena_i`, and `irq_o` is the OR of `irq_st_o`.
- R11: With `auto_resume_i` = 1, a completed suspend issues the resume opcode one idle cycle after its last poll acknowledge, with no new request.
- R12: A request that arrives while a sequence runs is kept and served after the block returns to idle. When a suspend and a resume are both pending, the suspend runs first.
- R13: Once `cmd_req_o` is raised, it and `cmd_code_o` hold their values until the cycle in which `cmd_ack_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sus_req_i | input | 1 | Suspend request pulse |
| auto_sus_req_i | input | 1 | Automatic suspend request pulse |
| res_req_i | input | 1 | Resume request pulse |
| sus_opcode_i | input | 8 | Suspend opcode (usually 0x75) |
| res_opcode_i | input | 8 | Resume opcode (usually 0x7A) |
| poll_cmd_i | input | 16 | Status read command |
| poll_cmd_wide_i | input | 1 | Send all 16 poll command bits |
| poll_two_byte_i | input | 1 | Read two status bytes |
| sus_mask_i | input | 16 | XOR mask that yields the indicator bits |
| sus_chk_en_i | input | 1 | Suspend needs the indicator check as well as bit 0 |
| res_chk_en_i | input | 1 | Resume needs the indicator check as well as bit 0 |
| retry_limit_i | input | 7 | Indicator failures that force a pass |
| sus_wait_en_i | input | 1 | Wait after the suspend opcode |
| res_wait_en_i | input | 1 | Wait after the resume opcode |
| sus_wait_long_i | input | 1 | Suspend wait scale: 1 = x128, 0 = x4 |
| res_wait_long_i | input | 1 | Resume wait scale: 1 = x128, 0 = x4 |
| wait_base_i | input | 10 | Wait base count |
| auto_resume_i | input | 1 | Start a resume after each completed suspend |
| cmd_req_o | output | 1 | Command request to the engine |
| cmd_code_o | output | 16 | Command bits to shift out |
| cmd_wide_o | output | 1 | 1: 16 command bits, 0: 8 |
| cmd_rd_bytes_o | output | 2 | Status bytes to read back |
| cmd_ack_i | input | 1 | Engine finished the command (one-cycle pulse) |
| cmd_rd_data_i | input | 16 | Status read back, valid with the acknowledge |
| irq_ena_i | input | 2 | Interrupt enables: bit 0 suspend-end, bit 1 resume-end |
| irq_clr_i | input | 2 | Interrupt clears |
| irq_raw_o | output | 2 | Raw interrupt bits |
| irq_st_o | output | 2 | Masked interrupt bits |
| irq_o | output | 1 | Interrupt line |
| suspended_o | output | 1 | Flash is in the suspended state |

## Verification
The bench builds the block with its default parameters: 16-bit status, 7-bit retry count, 10-bit wait base, and wait scales of 4 and 128. It keeps `wait_base_i` small at run time, so both the short and the long wait can be measured exactly within the run. The default status width makes the upper-byte masking matter. The bench gives a one-byte read a nonzero upper byte, which would pass the suspend check only if that byte were wrongly used. A retry limit of 3 and a limit of 0 reach both edges of the forced-pass rule.

// File: rtl/fsusp_pkg.sv
package fsusp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEND_OP = 3'd1,
        ST_WAIT    = 3'd2,
        ST_POLL    = 3'd3,
        ST_EVAL    = 3'd4
    } seq_state_e;

    typedef enum logic {
        DIR_SUSPEND = 1'b0,
        DIR_RESUME  = 1'b1
    } seq_dir_e;

    localparam int IRQ_SUS_END = 0;
    localparam int IRQ_RES_END = 1;
    localparam int IRQ_NUM     = 2;

endpackage

// File: rtl/fsusp_wait_timer.sv
module fsusp_wait_timer #(
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             last_o
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.cnt = len_i;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign last_o = (t_q.cnt == LEN_W'(1));

    // R5
    wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.cnt > LEN_W'(1) && !start_i) |=> (t_q.cnt == $past(t_q.cnt) - LEN_W'(1)));

endmodule

// File: rtl/fsusp_status_judge.sv
module fsusp_status_judge #(
    parameter int STAT_W  = 16,
    parameter int RETRY_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               eval_i,
    input  logic               dir_resume_i,
    input  logic               chk_en_i,
    input  logic               two_byte_i,
    input  logic [STAT_W-1:0]  status_i,
    input  logic [STAT_W-1:0]  mask_i,
    input  logic [RETRY_W-1:0] limit_i,
    output logic               pass_o
);

    localparam int HALF_W = STAT_W / 2;

    typedef struct packed {
        logic [RETRY_W-1:0] fails;
    } judge_t;

    judge_t j_d, j_q;

    logic [STAT_W-1:0]  stat_eff;
    logic [STAT_W-1:0]  mask_eff;
    logic [STAT_W-1:0]  ind_vec;
    logic               busy_bit;
    logic               ind_set;
    logic               ind_ok;
    logic [RETRY_W:0]   fails_next;
    logic               forced;

    always_comb begin
        if (two_byte_i) begin
            stat_eff = status_i;
            mask_eff = mask_i;
        end else begin
            stat_eff = {{(STAT_W-HALF_W){1'b0}}, status_i[HALF_W-1:0]};
            mask_eff = {{(STAT_W-HALF_W){1'b0}}, mask_i[HALF_W-1:0]};
        end
        ind_vec    = stat_eff ^ mask_eff;
        busy_bit   = stat_eff[0];
        ind_set    = |ind_vec;
        ind_ok     = dir_resume_i ? !ind_set : ind_set;
        fails_next = {1'b0, j_q.fails} + (RETRY_W+1)'(1);
        forced     = (fails_next >= {1'b0, limit_i});
        pass_o     = !busy_bit && (!chk_en_i || ind_ok || forced);
    end

    always_comb begin
        j_d = j_q;
        if (clr_i) begin
            j_d.fails = '0;
        end else if (eval_i && !busy_bit && chk_en_i && !ind_ok && !forced) begin
            j_d.fails = fails_next[RETRY_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            j_q <= '0;
        end else begin
            j_q <= j_d;
        end
    end

    // R6
    busy_blocks_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && status_i[0]) |-> !pass_o);

endmodule

// File: rtl/fsusp_irq_bank.sv
module fsusp_irq_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] ena_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] st_o,
    output logic         any_o
);

    logic [N-1:0] raw_d, raw_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_comb begin
            raw_d[i] = raw_q[i];
            if (set_i[i]) begin
                raw_d[i] = 1'b1;
            end else if (clr_i[i]) begin
                raw_d[i] = 1'b0;
            end
        end

        // R10
        irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !raw_o[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_d;
        end
    end

    assign raw_o = raw_q;
    assign st_o  = raw_q & ena_i;
    assign any_o = |st_o;

endmodule

// File: rtl/fsusp_sequencer.sv
module fsusp_sequencer
    import fsusp_pkg::*;
#(
    parameter int STAT_W     = 16,
    parameter int OP_W       = 8,
    parameter int WAIT_W     = 10,
    parameter int SHORT_MULT = 4,
    parameter int LONG_MULT  = 128,
    parameter int LEN_W      = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sus_req_i,
    input  logic                auto_sus_req_i,
    input  logic                res_req_i,
    input  logic [OP_W-1:0]     sus_opcode_i,
    input  logic [OP_W-1:0]     res_opcode_i,
    input  logic [STAT_W-1:0]   poll_cmd_i,
    input  logic                poll_cmd_wide_i,
    input  logic                poll_two_byte_i,
    input  logic                sus_chk_en_i,
    input  logic                res_chk_en_i,
    input  logic                sus_wait_en_i,
    input  logic                res_wait_en_i,
    input  logic                sus_wait_long_i,
    input  logic                res_wait_long_i,
    input  logic [WAIT_W-1:0]   wait_base_i,
    input  logic                auto_resume_i,
    output logic                cmd_req_o,
    output logic [STAT_W-1:0]   cmd_code_o,
    output logic                cmd_wide_o,
    output logic [1:0]          cmd_rd_bytes_o,
    input  logic                cmd_ack_i,
    input  logic [STAT_W-1:0]   cmd_rd_data_i,
    output logic                tmr_start_o,
    output logic [LEN_W-1:0]    tmr_len_o,
    input  logic                tmr_last_i,
    output logic                judge_clr_o,
    output logic                judge_eval_o,
    output logic                judge_dir_resume_o,
    output logic                judge_chk_en_o,
    output logic [STAT_W-1:0]   judge_status_o,
    input  logic                judge_pass_i,
    output logic [IRQ_NUM-1:0]  irq_set_o,
    output logic                suspended_o
);

    localparam int BYTE_W = STAT_W / 2;

    typedef struct packed {
        seq_state_e          state;
        seq_dir_e            dir;
        logic                pend_sus;
        logic                pend_res;
        logic                suspended;
        logic [STAT_W-1:0]   status;
    } seq_t;

    seq_t s_d, s_q;

    logic             wait_en;
    logic             wait_long;
    logic [LEN_W-1:0] wait_mult;
    logic [LEN_W-1:0] wait_len;
    logic             launch;

    // wait length for the direction being run
    always_comb begin
        wait_en   = (s_q.dir == DIR_RESUME) ? res_wait_en_i   : sus_wait_en_i;
        wait_long = (s_q.dir == DIR_RESUME) ? res_wait_long_i : sus_wait_long_i;
        wait_mult = wait_long ? LEN_W'(LONG_MULT) : LEN_W'(SHORT_MULT);
        wait_len  = wait_en ? (LEN_W'(wait_base_i) * wait_mult) : '0;
    end

    // command port drive
    always_comb begin
        cmd_req_o      = 1'b0;
        cmd_code_o     = '0;
        cmd_wide_o     = 1'b0;
        cmd_rd_bytes_o = 2'd0;
        unique case (s_q.state)
            ST_SEND_OP: begin
                cmd_req_o  = 1'b1;
                cmd_code_o = (s_q.dir == DIR_RESUME)
                           ? {{(STAT_W-OP_W){1'b0}}, res_opcode_i}
                           : {{(STAT_W-OP_W){1'b0}}, sus_opcode_i};
            end
            ST_POLL: begin
                cmd_req_o      = 1'b1;
                cmd_wide_o     = poll_cmd_wide_i;
                cmd_code_o     = poll_cmd_wide_i
                               ? poll_cmd_i
                               : {{(STAT_W-BYTE_W){1'b0}}, poll_cmd_i[BYTE_W-1:0]};
                cmd_rd_bytes_o = poll_two_byte_i ? 2'd2 : 2'd1;
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        s_d         = s_q;
        launch      = 1'b0;
        tmr_start_o = 1'b0;
        irq_set_o   = '0;

        unique case (s_q.state)
            ST_IDLE: begin
                if (s_q.pend_sus) begin
                    launch    = 1'b1;
                    s_d.state = ST_SEND_OP;
                    s_d.dir   = DIR_SUSPEND;
                end else if (s_q.pend_res) begin
                    launch    = 1'b1;
                    s_d.state = ST_SEND_OP;
                    s_d.dir   = DIR_RESUME;
                end
            end
            ST_SEND_OP: begin
                if (cmd_ack_i) begin
                    if (wait_len != '0) begin
                        tmr_start_o = 1'b1;
                        s_d.state   = ST_WAIT;
                    end else begin
                        s_d.state   = ST_POLL;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_last_i) begin
                    s_d.state = ST_POLL;
                end
            end
            ST_POLL: begin
                if (cmd_ack_i) begin
                    s_d.status = cmd_rd_data_i;
                    s_d.state  = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (!judge_pass_i) begin
                    s_d.state = ST_POLL;
                end else if (s_q.dir == DIR_SUSPEND) begin
                    s_d.suspended          = 1'b1;
                    irq_set_o[IRQ_SUS_END] = 1'b1;
                    if (auto_resume_i) begin
                        s_d.state = ST_SEND_OP;
                        s_d.dir   = DIR_RESUME;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end else begin
                    s_d.suspended          = 1'b0;
                    irq_set_o[IRQ_RES_END] = 1'b1;
                    s_d.state              = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        // pending requests: cleared by a launch, new pulses are kept
        if (launch && s_d.dir == DIR_SUSPEND) begin
            s_d.pend_sus = 1'b0;
        end
        if (launch && s_d.dir == DIR_RESUME) begin
            s_d.pend_res = 1'b0;
        end
        s_d.pend_sus = s_d.pend_sus | sus_req_i | auto_sus_req_i;
        s_d.pend_res = s_d.pend_res | res_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, dir: DIR_SUSPEND, pend_sus: 1'b0,
                     pend_res: 1'b0, suspended: 1'b0, status: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tmr_len_o          = wait_len;
    assign judge_clr_o        = (s_q.state == ST_SEND_OP);
    assign judge_eval_o       = (s_q.state == ST_EVAL);
    assign judge_dir_resume_o = (s_q.dir == DIR_RESUME);
    assign judge_chk_en_o     = (s_q.dir == DIR_RESUME) ? res_chk_en_i : sus_chk_en_i;
    assign judge_status_o     = s_q.status;
    assign suspended_o        = s_q.suspended;

    // R13
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_code_o)));

    // R6
    repoll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_EVAL && !judge_pass_i) |=> (s_q.state == ST_POLL));

    // R12
    sus_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE && s_q.pend_sus) |=>
        (s_q.state == ST_SEND_OP && s_q.dir == DIR_SUSPEND));

    // R9
    sus_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_EVAL && judge_pass_i && s_q.dir == DIR_SUSPEND) |=> suspended_o);

endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
    import fsusp_pkg::*;
#(
    parameter int STAT_W     = 16,
    parameter int OP_W       = 8,
    parameter int WAIT_W     = 10,
    parameter int RETRY_W    = 7,
    parameter int SHORT_MULT = 4,
    parameter int LONG_MULT  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sus_req_i,
    input  logic                auto_sus_req_i,
    input  logic                res_req_i,
    input  logic [OP_W-1:0]     sus_opcode_i,
    input  logic [OP_W-1:0]     res_opcode_i,
    input  logic [STAT_W-1:0]   poll_cmd_i,
    input  logic                poll_cmd_wide_i,
    input  logic                poll_two_byte_i,
    input  logic [STAT_W-1:0]   sus_mask_i,
    input  logic                sus_chk_en_i,
    input  logic                res_chk_en_i,
    input  logic [RETRY_W-1:0]  retry_limit_i,
    input  logic                sus_wait_en_i,
    input  logic                res_wait_en_i,
    input  logic                sus_wait_long_i,
    input  logic                res_wait_long_i,
    input  logic [WAIT_W-1:0]   wait_base_i,
    input  logic                auto_resume_i,
    output logic                cmd_req_o,
    output logic [STAT_W-1:0]   cmd_code_o,
    output logic                cmd_wide_o,
    output logic [1:0]          cmd_rd_bytes_o,
    input  logic                cmd_ack_i,
    input  logic [STAT_W-1:0]   cmd_rd_data_i,
    input  logic [IRQ_NUM-1:0]  irq_ena_i,
    input  logic [IRQ_NUM-1:0]  irq_clr_i,
    output logic [IRQ_NUM-1:0]  irq_raw_o,
    output logic [IRQ_NUM-1:0]  irq_st_o,
    output logic                irq_o,
    output logic                suspended_o
);

    localparam int LEN_W = WAIT_W + $clog2(LONG_MULT) + 1;

    logic               tmr_start;
    logic [LEN_W-1:0]   tmr_len;
    logic               tmr_last;
    logic               judge_clr;
    logic               judge_eval;
    logic               judge_dir_resume;
    logic               judge_chk_en;
    logic [STAT_W-1:0]  judge_status;
    logic               judge_pass;
    logic [IRQ_NUM-1:0] irq_set;

    fsusp_sequencer #(
        .STAT_W     (STAT_W),
        .OP_W       (OP_W),
        .WAIT_W     (WAIT_W),
        .SHORT_MULT (SHORT_MULT),
        .LONG_MULT  (LONG_MULT),
        .LEN_W      (LEN_W)
    ) u_seq (
        .clk                (clk),
        .rst_n              (rst_n),
        .sus_req_i          (sus_req_i),
        .auto_sus_req_i     (auto_sus_req_i),
        .res_req_i          (res_req_i),
        .sus_opcode_i       (sus_opcode_i),
        .res_opcode_i       (res_opcode_i),
        .poll_cmd_i         (poll_cmd_i),
        .poll_cmd_wide_i    (poll_cmd_wide_i),
        .poll_two_byte_i    (poll_two_byte_i),
        .sus_chk_en_i       (sus_chk_en_i),
        .res_chk_en_i       (res_chk_en_i),
        .sus_wait_en_i      (sus_wait_en_i),
        .res_wait_en_i      (res_wait_en_i),
        .sus_wait_long_i    (sus_wait_long_i),
        .res_wait_long_i    (res_wait_long_i),
        .wait_base_i        (wait_base_i),
        .auto_resume_i      (auto_resume_i),
        .cmd_req_o          (cmd_req_o),
        .cmd_code_o         (cmd_code_o),
        .cmd_wide_o         (cmd_wide_o),
        .cmd_rd_bytes_o     (cmd_rd_bytes_o),
        .cmd_ack_i          (cmd_ack_i),
        .cmd_rd_data_i      (cmd_rd_data_i),
        .tmr_start_o        (tmr_start),
        .tmr_len_o          (tmr_len),
        .tmr_last_i         (tmr_last),
        .judge_clr_o        (judge_clr),
        .judge_eval_o       (judge_eval),
        .judge_dir_resume_o (judge_dir_resume),
        .judge_chk_en_o     (judge_chk_en),
        .judge_status_o     (judge_status),
        .judge_pass_i       (judge_pass),
        .irq_set_o          (irq_set),
        .suspended_o        (suspended_o)
    );

    fsusp_wait_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .len_i   (tmr_len),
        .last_o  (tmr_last)
    );

    fsusp_status_judge #(
        .STAT_W  (STAT_W),
        .RETRY_W (RETRY_W)
    ) u_judge (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (judge_clr),
        .eval_i       (judge_eval),
        .dir_resume_i (judge_dir_resume),
        .chk_en_i     (judge_chk_en),
        .two_byte_i   (poll_two_byte_i),
        .status_i     (judge_status),
        .mask_i       (sus_mask_i),
        .limit_i      (retry_limit_i),
        .pass_o       (judge_pass)
    );

    fsusp_irq_bank #(
        .N (IRQ_NUM)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .clr_i (irq_clr_i),
        .ena_i (irq_ena_i),
        .raw_o (irq_raw_o),
        .st_o  (irq_st_o),
        .any_o (irq_o)
    );

endmodule

// File: tb/tb_flash_suspend_ctrl.sv
`timescale 1ns/1ps
module tb_flash_suspend_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sus_req = 1'b0, auto_sus_req = 1'b0, res_req = 1'b0;
    logic [7:0]  sus_op = 8'h75, res_op = 8'h7A;
    logic [15:0] poll_cmd = 16'h3505;
    logic        poll_wide = 1'b0, poll_two = 1'b0;
    logic [15:0] mask = 16'h0000;
    logic        sus_chk = 1'b0, res_chk = 1'b0;
    logic [6:0]  limit = 7'd100;
    logic        sus_wen = 1'b0, res_wen = 1'b0, sus_wlong = 1'b0, res_wlong = 1'b0;
    logic [9:0]  wbase = 10'd0;
    logic        auto_res = 1'b0;
    logic        cmd_req;
    logic [15:0] cmd_code;
    logic        cmd_wide;
    logic [1:0]  cmd_rdb;
    logic        cmd_ack = 1'b0;
    logic [15:0] cmd_rd = 16'h0;
    logic [1:0]  irq_ena = 2'b00, irq_clr = 2'b00;
    logic [1:0]  irq_raw, irq_st;
    logic        irq;
    logic        suspended;

    always #10 clk = ~clk;

    flash_suspend_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .sus_req_i(sus_req), .auto_sus_req_i(auto_sus_req), .res_req_i(res_req),
        .sus_opcode_i(sus_op), .res_opcode_i(res_op),
        .poll_cmd_i(poll_cmd), .poll_cmd_wide_i(poll_wide), .poll_two_byte_i(poll_two),
        .sus_mask_i(mask), .sus_chk_en_i(sus_chk), .res_chk_en_i(res_chk),
        .retry_limit_i(limit),
        .sus_wait_en_i(sus_wen), .res_wait_en_i(res_wen),
        .sus_wait_long_i(sus_wlong), .res_wait_long_i(res_wlong),
        .wait_base_i(wbase), .auto_resume_i(auto_res),
        .cmd_req_o(cmd_req), .cmd_code_o(cmd_code), .cmd_wide_o(cmd_wide),
        .cmd_rd_bytes_o(cmd_rdb), .cmd_ack_i(cmd_ack), .cmd_rd_data_i(cmd_rd),
        .irq_ena_i(irq_ena), .irq_clr_i(irq_clr), .irq_raw_o(irq_raw),
        .irq_st_o(irq_st), .irq_o(irq), .suspended_o(suspended)
    );

    typedef struct packed {
        logic [15:0] code;
        logic        wide;
        logic [1:0]  rdb;
        logic [31:0] gap;
    } exp_t;

    localparam logic [31:0] ANY_GAP = 32'hFFFF_FFFF;

    exp_t        exp_q[$];
    string       tag_q[$];
    logic [15:0] rsp_q[$];
    int          vectors = 0;
    int          fails = 0;
    int          gap_cnt = 0;
    bit          finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic push_op(input logic [7:0] op, input logic [31:0] gap, input string tag);
        exp_q.push_back('{code: {8'h00, op}, wide: 1'b0, rdb: 2'd0, gap: gap});
        tag_q.push_back(tag);
    endtask

    task automatic push_poll(input logic [31:0] gap, input logic [15:0] rsp, input string tag);
        exp_t e;
        e.code = poll_wide ? poll_cmd : {8'h00, poll_cmd[7:0]};
        e.wide = poll_wide;
        e.rdb  = poll_two ? 2'd2 : 2'd1;
        e.gap  = gap;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rsp_q.push_back(rsp);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) sus_req = 1'b1;
        if (which == 1) res_req = 1'b1;
        if (which == 2) auto_sus_req = 1'b1;
        if (which == 3) begin sus_req = 1'b1; res_req = 1'b1; end
        @(negedge clk);
        sus_req = 1'b0; res_req = 1'b0; auto_sus_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 2'b11;
        @(negedge clk);
        irq_clr = 2'b00;
    endtask

    // engine model and scoreboard monitor
    initial begin
        @(posedge rst_n);
        @(negedge clk);
        forever begin
            if (cmd_req) begin
                logic [15:0] seen_code;
                logic [15:0] rsp;
                seen_code = cmd_code;
                rsp = 16'h0;
                if (exp_q.size() == 0) begin
                    vectors++;
                    fails++;
                    $display("FAIL R6: unexpected command got %0h expected none", cmd_code);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " code"}, {16'h0, cmd_code}, {16'h0, e.code});
                    chk({t, " wide"}, {31'h0, cmd_wide}, {31'h0, e.wide});
                    chk({t, " read bytes"}, {30'h0, cmd_rdb}, {30'h0, e.rdb});
                    if (e.gap != ANY_GAP) chk({t, " idle gap"}, gap_cnt, e.gap);
                end
                if (cmd_rdb != 2'd0 && rsp_q.size() != 0) rsp = rsp_q.pop_front();
                @(negedge clk);
                chk("R13 code held", {16'h0, cmd_code}, {16'h0, seen_code});
                cmd_ack = 1'b1;
                cmd_rd  = rsp;
                @(negedge clk);
                cmd_ack = 1'b0;
                cmd_rd  = 16'h0;
                gap_cnt = 0;
            end else begin
                gap_cnt++;
                @(negedge clk);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd_req", {31'h0, cmd_req}, 0);
        chk("R1 suspended", {31'h0, suspended}, 0);
        chk("R1 irq_raw", {30'h0, irq_raw}, 0);
        chk("R1 irq_st", {30'h0, irq_st}, 0);
        chk("R1 irq", {31'h0, irq}, 0);

        // R2 suspend opcode, R4 low-byte poll, R6 busy repoll
        push_op(8'h75, ANY_GAP, "R2 suspend opcode");
        push_poll(0, 16'h0001, "R4 narrow poll");
        push_poll(1, 16'h0000, "R6 busy repoll");
        pulse(0);
        drain();
        chk("R9 suspended set", {31'h0, suspended}, 1);
        chk("R10 raw suspend-end", {30'h0, irq_raw}, 2'b01);
        chk("R10 st masked", {30'h0, irq_st}, 2'b00);
        chk("R10 irq masked", {31'h0, irq}, 0);
        irq_ena = 2'b11;
        @(negedge clk);
        chk("R10 st enabled", {30'h0, irq_st}, 2'b01);
        chk("R10 irq enabled", {31'h0, irq}, 1);
        @(negedge clk);
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R10 cleared", {30'h0, irq_raw}, 2'b00);

        // R3 resume, R4 wide two-byte poll, R5 short wait, R7 resume rule
        poll_cmd = 16'hAB05; poll_wide = 1'b1; poll_two = 1'b1;
        res_chk = 1'b1; mask = 16'h8000;
        res_wen = 1'b1; res_wlong = 1'b0; wbase = 10'd3;
        push_op(8'h7A, ANY_GAP, "R3 resume opcode");
        push_poll(12, 16'h0000, "R5 short wait");
        push_poll(1, 16'h8000, "R7 resume vector nonzero");
        pulse(1);
        drain();
        chk("R9 suspended cleared", {31'h0, suspended}, 0);
        chk("R10 raw resume-end", {30'h0, irq_raw}, 2'b10);
        clear_irq();

        // R5 long wait, R7 upper byte ignored, R8 forced pass at limit 3
        poll_cmd = 16'h3505; poll_wide = 1'b0; poll_two = 1'b0;
        res_chk = 1'b0; sus_chk = 1'b1; mask = 16'h8000; limit = 7'd3;
        res_wen = 1'b0; sus_wen = 1'b1; sus_wlong = 1'b1; wbase = 10'd2;
        push_op(8'h75, ANY_GAP, "R2 suspend opcode");
        push_poll(256, 16'h4000, "R5 long wait");
        push_poll(1, 16'h0000, "R7 upper byte ignored");
        push_poll(1, 16'h4000, "R8 third failure");
        pulse(0);
        drain();
        chk("R8 forced pass", {31'h0, suspended}, 1);
        chk("R8 raw suspend-end", {30'h0, irq_raw}, 2'b01);
        clear_irq();

        // R7 suspend pass on nonzero vector, R6 busy not counted
        sus_wen = 1'b0; wbase = 10'd0; limit = 7'd100;
        poll_two = 1'b1; mask = 16'h0000;
        push_op(8'h75, ANY_GAP, "R2 suspend opcode");
        push_poll(0, 16'h0003, "R6 busy with check");
        push_poll(1, 16'h0002, "R7 suspend vector");
        pulse(0);
        drain();
        chk("R7 suspend passed", {30'h0, irq_raw}, 2'b01);
        clear_irq();

        // R11 automatic suspend chained into resume
        sus_chk = 1'b0; poll_two = 1'b0; auto_res = 1'b1;
        push_op(8'h75, ANY_GAP, "R2 auto suspend opcode");
        push_poll(0, 16'h0000, "R4 poll");
        push_op(8'h7A, 1, "R11 chained resume");
        push_poll(0, 16'h0000, "R4 poll");
        pulse(2);
        drain();
        chk("R11 suspended cleared", {31'h0, suspended}, 0);
        chk("R11 both ends raised", {30'h0, irq_raw}, 2'b11);
        auto_res = 1'b0;
        clear_irq();

        // R12 resume requested while suspend runs
        push_op(8'h75, ANY_GAP, "R12 running suspend");
        push_poll(0, 16'h0000, "R4 poll");
        push_op(8'h7A, ANY_GAP, "R12 held resume");
        push_poll(0, 16'h0000, "R4 poll");
        pulse(0);
        repeat (3) @(negedge clk);
        pulse(1);
        drain();
        chk("R12 held resume done", {31'h0, suspended}, 0);
        chk("R12 both ends raised", {30'h0, irq_raw}, 2'b11);
        clear_irq();

        // R12 simultaneous requests: suspend first
        push_op(8'h75, ANY_GAP, "R12 suspend priority");
        push_poll(0, 16'h0000, "R4 poll");
        push_op(8'h7A, ANY_GAP, "R12 resume second");
        push_poll(0, 16'h0000, "R4 poll");
        pulse(3);
        drain();
        chk("R12 resume last", {31'h0, suspended}, 0);
        clear_irq();

        // R8 limit of zero passes on first failure
        sus_chk = 1'b1; mask = 16'h0000; limit = 7'd0;
        push_op(8'h75, ANY_GAP, "R2 suspend opcode");
        push_poll(0, 16'h0000, "R8 limit zero");
        pulse(0);
        drain();
        chk("R8 limit zero passed", {31'h0, suspended}, 1);
        chk("R6 responses consumed", rsp_q.size(), 0);

        finish_run();
    end

endmodule